// File: doc/BRIEF.md
# Lane Word Aligner with Bit-Slip Search

This block corrects integer-bit skew on one serial lane after it has been turned into bytes. It holds the last few raw bytes in a short history. Each output byte is an 8-bit window cut from that history at a programmable bit offset. This lets lanes whose bits arrive several bit-times apart all present whole words on the same clock.

A comparator checks each aligned byte against an expected training word. It raises a lock flag once a set number of consecutive aligned words have matched. A small search controller sets the offset without software help. It runs in one of two modes:
- Reference mode, used for the lane that times the others. The controller sweeps a fixed offset range.
- Data-lane mode. The controller tries offsets at growing distance from the reference lane's offset, within a bounded skew window. It keeps the first one that locks.

If no candidate locks, the controller reports the failure. The offset can also be written by hand while the controller is idle.

Top module: `bitslip_lane_aligner`

## Requirements
- R1: After reset:
  - offset_o is 0;
  - lock_o, busy_o, no_match_o and data_vld_o are all 0.
- R2: On every cycle with byte_vld_i high, the block accepts byte_i as the newest byte of a 24-bit history H. The newest byte sits in H[7:0], and older bytes sit at higher bits. In the next cycle data_vld_o is 1 and data_o equals H[offset_o+7 : offset_o]. In a cycle after byte_vld_i was low, data_vld_o is 0 and H does not move.
- R3: A write with offset_wr_i high loads offset_i. The new offset is used for data_o from the next cycle on. A write with offset_i above 16 is ignored.
- R4: lock_o rises once 4 consecutive valid aligned words have equalled train_word_i. lock_o is 1 in the cycle after the 4th matching word is presented. lock_o clears in the cycle after a valid word that mismatches. It also clears whenever the offset changes.
- R5: With ref_mode_i high, a search tries offsets 3, 4, ..., 12 in ascending order. It ends with offset_o at the first offset that locks.
- R6: With ref_mode_i low, a search tries ref_ofs_i + 0, -1, +1, -2, +2, -3, +3 in that order. Candidates outside 0..16 are skipped. The search ends with offset_o at the first offset that locks. This gives the closest match, with the lower offset taken on a tie.
- R7: When every candidate has failed, the search ends with no_match_o = 1 and lock_o = 0. The next search start clears no_match_o.
- R8: An offset write is ignored while busy_o is high. It is also ignored in the same cycle as search_start_i, where the start takes priority.
- R9: busy_o is 1 in the cycle after search_start_i. It stays 1 until the search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Clock enable for the raw byte |
| byte_i | input | 8 | Raw deserialized byte |
| offset_wr_i | input | 1 | Manual offset write strobe |
| offset_i | input | 5 | Manual offset value |
| train_word_i | input | 8 | Expected training word |
| search_start_i | input | 1 | Start an offset search |
| ref_mode_i | input | 1 | 1: reference-lane sweep, 0: data-lane window |
| ref_ofs_i | input | 5 | Reference lane offset, the centre of the data-lane window |
| data_o | output | 8 | Aligned byte |
| data_vld_o | output | 1 | data_o holds a new aligned byte |
| offset_o | output | 5 | Offset in use |
| lock_o | output | 1 | Training word matched for 4 consecutive words |
| busy_o | output | 1 | Search in progress |
| no_match_o | output | 1 | Last search found no locking offset |

## Verification
Two functions can fall in the same cycle: a manual offset write and the search controller's own ownership of the offset register. The bench provokes this by raising offset_wr_i in the same cycle as search_start_i. It then keeps the write asserted on every cycle while busy_o is high, and drops it on the first idle cycle. The result is judged by comparing offset_o with the offset the bench computes from the candidate order. If any write had slipped through, offset_o would show the written value instead.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  typedef enum logic [1:0] {
    SRCH_IDLE,
    SRCH_PICK,
    SRCH_TRY
  } srch_state_e;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bitslip_history.sv
module bitslip_history #(
  parameter int BYTE_W     = 8,
  parameter int HIST_BYTES = 3,
  parameter int OFS_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [BYTE_W-1:0] win_o,
  output logic              vld_o
);
  localparam int HIST_W = BYTE_W * HIST_BYTES;

  logic [HIST_W-1:0] hist;

  // stage 0 holds the newest byte, at the low end of hist
  for (genvar g = 0; g < HIST_BYTES; g++) begin : g_stage
    logic [BYTE_W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= '0;
        else if (vld_i) q <= byte_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= '0;
        else if (vld_i) q <= g_stage[g-1].q;
      end
    end
    assign hist[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb win_o = BYTE_W'(hist >> ofs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end
endmodule

// File: rtl/bitslip_lock_ctr.sv
module bitslip_lock_ctr #(
  parameter int BYTE_W   = 8,
  parameter int LOCK_CNT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] word_i,
  input  logic [BYTE_W-1:0] train_i,
  input  logic              clr_i,
  output logic              lock_o,
  output logic              miss_o
);
  localparam int CNT_W = $clog2(LOCK_CNT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign lock_o = (cnt_q == CNT_W'(LOCK_CNT));
  assign miss_o = vld_i && (word_i != train_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (vld_i) begin
      if (word_i != train_i)       cnt_q <= '0;
      else if (!lock_o)            cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bitslip_search.sv
module bitslip_search
  import bitslip_pkg::*;
#(
  parameter int OFS_W   = 5,
  parameter int MAX_OFS = 16,
  parameter int REF_MIN = 3,
  parameter int REF_MAX = 12,
  parameter int SKEW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ref_mode_i,
  input  logic [OFS_W-1:0] ref_ofs_i,
  input  logic             lock_i,
  input  logic             miss_i,
  output logic             load_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             busy_o,
  output logic             no_match_o
);
  localparam int N_REF  = REF_MAX - REF_MIN + 1;
  localparam int N_LANE = 2 * SKEW + 1;
  localparam int N_MAX  = max_int(N_REF, N_LANE);
  localparam int IDX_W  = $clog2(N_MAX + 1);

  srch_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             no_match_q;
  int               n_cand, mag, cand;
  logic             exhausted, in_range;

  // candidate idx: ref sweep ascending, lane window 0,-1,+1,-2,+2,...
  always_comb begin
    n_cand    = ref_mode_i ? N_REF : N_LANE;
    mag       = (int'(idx_q) + 1) / 2;
    if (ref_mode_i)    cand = REF_MIN + int'(idx_q);
    else if (idx_q[0]) cand = int'(ref_ofs_i) - mag;
    else               cand = int'(ref_ofs_i) + mag;
    exhausted = int'(idx_q) >= n_cand;
    in_range  = (cand >= 0) && (cand <= MAX_OFS);
    load_o    = (state_q == SRCH_PICK) && !exhausted && in_range;
    ofs_o     = OFS_W'(cand);
  end

  assign busy_o     = (state_q != SRCH_IDLE);
  assign no_match_o = no_match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SRCH_IDLE;
      idx_q      <= '0;
      no_match_q <= 1'b0;
    end else if (start_i) begin
      state_q    <= SRCH_PICK;
      idx_q      <= '0;
      no_match_q <= 1'b0;
    end else begin
      unique case (state_q)
        SRCH_PICK: begin
          if (exhausted) begin
            state_q    <= SRCH_IDLE;
            no_match_q <= 1'b1;
          end else if (in_range) begin
            state_q <= SRCH_TRY;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SRCH_TRY: begin
          if (lock_i) begin
            state_q <= SRCH_IDLE;
          end else if (miss_i) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SRCH_PICK;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bitslip_lane_aligner.sv
module bitslip_lane_aligner #(
  parameter int BYTE_W     = 8,
  parameter int HIST_BYTES = 3,
  parameter int REF_MIN    = 3,
  parameter int REF_MAX    = 12,
  parameter int SKEW       = 3,
  parameter int LOCK_CNT   = 4,
  localparam int HIST_W    = BYTE_W * HIST_BYTES,
  localparam int MAX_OFS   = HIST_W - BYTE_W,
  localparam int OFS_W     = $clog2(MAX_OFS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              offset_wr_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [BYTE_W-1:0] train_word_i,
  input  logic              search_start_i,
  input  logic              ref_mode_i,
  input  logic [OFS_W-1:0]  ref_ofs_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_vld_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic              lock_o,
  output logic              busy_o,
  output logic              no_match_o
);
  logic [OFS_W-1:0] ofs_q, srch_ofs;
  logic             srch_load, srch_busy, wr_ok, ofs_load;
  logic             miss;

  bitslip_history #(
    .BYTE_W(BYTE_W), .HIST_BYTES(HIST_BYTES), .OFS_W(OFS_W)
  ) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (byte_vld_i),
    .byte_i(byte_i),
    .ofs_i (ofs_q),
    .win_o (data_o),
    .vld_o (data_vld_o)
  );

  bitslip_lock_ctr #(
    .BYTE_W(BYTE_W), .LOCK_CNT(LOCK_CNT)
  ) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (data_vld_o),
    .word_i (data_o),
    .train_i(train_word_i),
    .clr_i  (ofs_load),
    .lock_o (lock_o),
    .miss_o (miss)
  );

  bitslip_search #(
    .OFS_W(OFS_W), .MAX_OFS(MAX_OFS), .REF_MIN(REF_MIN),
    .REF_MAX(REF_MAX), .SKEW(SKEW)
  ) u_srch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (search_start_i),
    .ref_mode_i(ref_mode_i),
    .ref_ofs_i (ref_ofs_i),
    .lock_i    (lock_o),
    .miss_i    (miss),
    .load_o    (srch_load),
    .ofs_o     (srch_ofs),
    .busy_o    (srch_busy),
    .no_match_o(no_match_o)
  );

  // manual write only while idle; start owns the register
  assign wr_ok    = offset_wr_i && !srch_busy && !search_start_i &&
                    (int'(offset_i) <= MAX_OFS);
  assign ofs_load = srch_load || wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ofs_q <= '0;
    else if (srch_load) ofs_q <= srch_ofs;
    else if (wr_ok)     ofs_q <= offset_i;
  end

  assign offset_o = ofs_q;
  assign busy_o   = srch_busy;
endmodule

// File: rtl/bitslip_lane_aligner_chk.sv
module bitslip_lane_aligner_chk #(
  parameter int BYTE_W  = 8,
  parameter int OFS_W   = 5,
  parameter int MAX_OFS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic              search_start_i,
  input logic [BYTE_W-1:0] train_word_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              data_vld_o,
  input logic [OFS_W-1:0]  offset_o,
  input logic              lock_o,
  input logic              busy_o,
  input logic              no_match_o
);
  a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> data_vld_o);

  a_r3_ofs_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(offset_o) <= MAX_OFS);

  a_r4_miss_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_o && (data_o != train_word_i)) |=> !lock_o);

  a_r4_ofs_change_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) |-> !lock_o);

  a_r7_no_match_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_match_o |-> !busy_o);

  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_start_i |=> busy_o);
endmodule

bind bitslip_lane_aligner bitslip_lane_aligner_chk #(
  .BYTE_W(BYTE_W), .OFS_W(OFS_W), .MAX_OFS(MAX_OFS)
) u_chk (.*);

// File: tb/bitslip_lane_aligner_tb_top.sv
module bitslip_lane_aligner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] TW = 8'hB4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       offset_wr_i = 1'b0;
  logic [4:0] offset_i = '0;
  logic [7:0] train_word_i = TW;
  logic       search_start_i = 1'b0;
  logic       ref_mode_i = 1'b0;
  logic [4:0] ref_ofs_i = '0;
  logic [7:0] data_o;
  logic       data_vld_o;
  logic [4:0] offset_o;
  logic       lock_o, busy_o, no_match_o;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [23:0] bh = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitslip_lane_aligner dut_i (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] win(logic [23:0] h, int o);
    return 8'(h >> o);
  endfunction

  task automatic push(logic [7:0] b);
    byte_i = b;
    byte_vld_i = 1'b1;
    bh = {bh[15:0], b};
    tick();
  endtask

  task automatic wr_ofs(int o);
    offset_i = 5'(o);
    offset_wr_i = 1'b1;
    tick();
    offset_wr_i = 1'b0;
  endtask

  task automatic fill(logic [7:0] r);
    for (int i = 0; i < 4; i++) push(r);
  endtask

  task automatic wait_idle(bit hold_wr);
    int guard = 0;
    while (busy_o && guard < 500) begin
      offset_wr_i = hold_wr;
      offset_i = 5'd2;
      tick();
      guard++;
    end
    offset_wr_i = 1'b0;
    if (guard >= 500) check("R9 search hang", 1, 0);
  endtask

  task automatic search(bit refm, int rofs, bit wr_with_start);
    ref_mode_i = refm;
    ref_ofs_i = 5'(rofs);
    search_start_i = 1'b1;
    offset_wr_i = wr_with_start;
    offset_i = 5'd5;
    tick();
    search_start_i = 1'b0;
    check("R9 busy after start", int'(busy_o), 1);
    wait_idle(wr_with_start);
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] r;
    int exp;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 offset", int'(offset_o), 0);
    check("R1 lock", int'(lock_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 no_match", int'(no_match_o), 0);
    check("R1 data_vld", int'(data_vld_o), 0);
    rst_ni = 1'b1;
    tick();
    check("R1 data_vld idle", int'(data_vld_o), 0);

    // R2/R3 window sweep over every offset with varied bytes
    b = 8'h17;
    for (int o = 0; o <= 16; o++) begin
      wr_ofs(o);
      check("R3 offset loaded", int'(offset_o), o);
      for (int k = 0; k < 5; k++) begin
        b = b * 8'd5 + 8'h3B;
        push(b);
        check("R2 data_vld", int'(data_vld_o), 1);
        check("R2 window", int'(data_o), int'(win(bh, o)));
      end
      byte_vld_i = 1'b0;
      byte_i = ~b;
      tick();
      check("R2 vld low", int'(data_vld_o), 0);
      check("R2 hist held", int'(data_o), int'(win(bh, o)));
    end
    // R3 offset change on next cycle with held history
    wr_ofs(3);
    check("R3 next cycle", int'(data_o), int'(win(bh, 3)));
    // R3 out-of-range write ignored
    wr_ofs(20);
    check("R3 oor ignored", int'(offset_o), 3);
    wr_ofs(31);
    check("R3 oor ignored 31", int'(offset_o), 3);

    // R4 lock timing
    fill(TW);
    wr_ofs(0);
    check("R4 unlocked at load", int'(lock_o), 0);
    tick(); tick();
    push(TW);
    check("R4 lock after 3", int'(lock_o), 0);
    push(TW);
    check("R4 lock after 4", int'(lock_o), 1);
    push(8'h00);
    check("R4 still locked at miss word", int'(lock_o), 1);
    push(TW);
    check("R4 miss clears", int'(lock_o), 0);
    fill(TW);
    repeat (4) tick();
    check("R4 relock", int'(lock_o), 1);
    wr_ofs(8);
    check("R4 ofs change clears", int'(lock_o), 0);

    // R8 write with start and during busy: ref sweep on R=TW locks at 8
    search(1'b1, 0, 1'b1);
    check("R8 start wins offset", int'(offset_o), 8);
    check("R8 locked", int'(lock_o), 1);

    // R5 reference sweep over all skews
    for (int s = 0; s < 8; s++) begin
      r = 8'({TW, TW} >> s);
      fill(r);
      exp = -1;
      for (int o = 3; o <= 12; o++)
        if (exp < 0 && win({r, r, r}, o) == TW) exp = o;
      search(1'b1, 0, 1'b0);
      check("R5 ref offset", int'(offset_o), exp);
      check("R5 ref lock", int'(lock_o), 1);
      check("R7 ref no_match", int'(no_match_o), 0);
    end

    // R6/R7 data-lane window for every centre and skew
    for (int c = 0; c <= 16; c++) begin
      for (int s = 0; s < 8; s++) begin
        r = 8'({TW, TW} >> s);
        fill(r);
        exp = -1;
        for (int k = 0; k < 7; k++) begin
          int m;
          int d;
          m = (k + 1) / 2;
          d = (k % 2 == 1) ? -m : m;
          if (exp < 0 && c + d >= 0 && c + d <= 16 &&
              win({r, r, r}, c + d) == TW) exp = c + d;
        end
        search(1'b0, c, 1'b0);
        if (exp >= 0) begin
          check("R6 lane offset", int'(offset_o), exp);
          check("R6 lane lock", int'(lock_o), 1);
          check("R7 lane no_match clear", int'(no_match_o), 0);
        end else begin
          check("R7 no_match set", int'(no_match_o), 1);
          check("R7 no lock", int'(lock_o), 0);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule